// File: doc/BRIEF.md
# Self-Test Frame Launch Controller

This block is a 32-bit control/status register with per-port trigger logic that starts a built-in self-test frame toward a serial storage device on one of four ports. Software writes a 1 into a port's initiate bit. The block sees the 0-to-1 change of that stored bit, checks that the port may take a test, and pulses a one-cycle launch request with a port number to a transmit engine.

The transmit engine answers with a completion strobe that carries a good or an error status. The block records the outcome in two write-1-to-clear flags. After a good completion it bars that port from further launches until the port's enable input goes low and then high again. Only one test may be in flight at a time. A busy output tells the transmit engine that a launch is still waiting for its completion.

Top module: `stf_launch_ctrl`

## Requirements
- R1: The register answers only at address E0h. Every field reads 0 after reset, and a write to any other address changes nothing.
- R2: The initiate bits are read/write, with port 0 at bit 7, port 1 at bit 8, port 2 at bit 11 and port 3 at bit 13. A write that changes such a bit from 0 to 1 gives exactly one `launch_req` pulse, one cycle wide. The pulse starts at the second rising edge after the write edge. Keeping the bit at 1 gives no further pulses.
- R3: A rising initiate bit starts a launch only if `port_present` and `port_ready` are both 1 for that port. Otherwise the edge is dropped and is not kept for later.
- R4: A completion (`tx_done`=1) with `tx_ok`=1 sets the success flag (bit 10). A completion with `tx_ok`=0 sets the failure flag (bit 9). The new flag value reads back from the edge at which `tx_done` is sampled.
- R5: Writing 1 to bit 10 or bit 9 clears that flag, and writing 0 leaves it unchanged. A flag that is set still allows a launch.
- R6: After a failure, clearing a port's initiate bit and then setting it again starts a new launch, with no limit on the number of retries.
- R7: After a success, that port accepts no launch until its `port_enable` has gone from 0 to 1. Other ports are not affected.
- R8: `busy` is 1 from the launch pulse until the completion edge. An initiate edge seen while busy is dropped, and a `tx_done` while not busy changes nothing.
- R9: Bits 31:14, bit 12 and bits 6:0 always read 0.
- R10: If several eligible ports rise in the same cycle, the lowest-numbered port is launched and the others are dropped.
- R11: `launch_port` gives the launched port's number in binary and is valid while `launch_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register contents |
| port_present | input | 4 | Device attached, one bit per port |
| port_ready | input | 4 | Link active and not in a low-power state, one bit per port |
| port_enable | input | 4 | Port enable, one bit per port |
| tx_done | input | 1 | Completion strobe from the transmit engine |
| tx_ok | input | 1 | Completion status: 1 good, 0 error |
| launch_req | output | 1 | One-cycle launch request |
| launch_port | output | 2 | Port number of the launch |
| busy | output | 1 | A launch is waiting for its completion |

## Verification
A write takes effect at the first rising edge after the write edge, and `launch_req` follows one edge later. So the bench checks for the pulse at the second falling edge after the write and checks that it is gone at the falling edge after that. Flag and busy changes from `tx_done`, and W1C clears, are checked at the falling edge just after the sampling edge. The sweep covers every port with every combination of presence and readiness. Dropped edges and lock-outs are checked by watching `launch_req` over the cycles in which a pulse would otherwise be due.

// File: rtl/stf_pkg.sv
package stf_pkg;
  localparam int NPORT  = 4;
  localparam int PW     = $clog2(NPORT);
  localparam int DW     = 32;
  localparam int OK_BIT  = 10;
  localparam int ERR_BIT = 9;

  // bit position of each port's initiate field
  function automatic int init_pos(input int p);
    case (p)
      0:       return 7;
      1:       return 8;
      2:       return 11;
      default: return 13;
    endcase
  endfunction

  // mask of every implemented bit
  function automatic logic [DW-1:0] live_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int p = 0; p < NPORT; p++) m[init_pos(p)] = 1'b1;
    m[OK_BIT]  = 1'b1;
    m[ERR_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/stf_edge_detect.sv
module stf_edge_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/stf_status_reg.sv
module stf_status_reg
  import stf_pkg::*;
#(
  parameter int N = NPORT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic          set_ok,
  input  logic          set_err,
  output logic [N-1:0]  init_q,
  output logic          ok_q,
  output logic          err_q
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar p = 0; p < N; p++) begin : g_init
    always_ff @(posedge clk) begin
      if (rst)         init_q[p] <= 1'b0;
      else if (wr_hit) init_q[p] <= wdata[init_pos(p)];
    end
  end

  // a new completion wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (set_ok)                         ok_q <= 1'b1;
      else if (wr_hit && wdata[OK_BIT])   ok_q <= 1'b0;
      if (set_err)                        err_q <= 1'b1;
      else if (wr_hit && wdata[ERR_BIT])  err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stf_launch_arbiter.sv
module stf_launch_arbiter #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  rise,
  input  logic [N-1:0]  present,
  input  logic [N-1:0]  ready,
  input  logic [N-1:0]  enable,
  input  logic          tx_done,
  input  logic          tx_ok,
  output logic          launch_req,
  output logic [PW-1:0] launch_port,
  output logic          busy,
  output logic          done_ok,
  output logic          done_err
);
  logic [N-1:0]  en_prev_q;
  logic [N-1:0]  locked_q;
  logic [PW-1:0] cur_q;
  logic [N-1:0]  elig;
  logic [PW-1:0] pick;
  logic          any;

  assign elig = rise & present & ready & ~locked_q;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int p = N - 1; p >= 0; p--) begin
      if (elig[p]) begin
        pick = PW'(p);
        any  = 1'b1;
      end
    end
  end

  assign done_ok  = busy & tx_done & tx_ok;
  assign done_err = busy & tx_done & ~tx_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev_q   <= '0;
      locked_q    <= '0;
      cur_q       <= '0;
      busy        <= 1'b0;
      launch_req  <= 1'b0;
      launch_port <= '0;
    end else begin
      launch_req <= 1'b0;
      en_prev_q  <= enable;
      for (int p = 0; p < N; p++)
        if (enable[p] && !en_prev_q[p]) locked_q[p] <= 1'b0;
      if (busy) begin
        if (tx_done) begin
          busy <= 1'b0;
          if (tx_ok) locked_q[cur_q] <= 1'b1;
        end
      end else if (any) begin
        launch_req  <= 1'b1;
        launch_port <= pick;
        cur_q       <= pick;
        busy        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stf_launch_ctrl.sv
module stf_launch_ctrl
  import stf_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'hE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NPORT-1:0]  port_present,
  input  logic [NPORT-1:0]  port_ready,
  input  logic [NPORT-1:0]  port_enable,
  input  logic              tx_done,
  input  logic              tx_ok,
  output logic              launch_req,
  output logic [PW-1:0]     launch_port,
  output logic              busy
);
  logic             wr_hit;
  logic [NPORT-1:0] init_q;
  logic [NPORT-1:0] init_rise;
  logic             ok_q, err_q;
  logic             done_ok, done_err;

  assign wr_hit = reg_wr && (reg_addr == REG_OFFSET);

  stf_status_reg #(.N(NPORT)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wdata   (reg_wdata),
    .set_ok  (done_ok),
    .set_err (done_err),
    .init_q  (init_q),
    .ok_q    (ok_q),
    .err_q   (err_q)
  );

  stf_edge_detect #(.W(NPORT)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (init_q),
    .rise  (init_rise)
  );

  stf_launch_arbiter #(.N(NPORT), .PW(PW)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .rise        (init_rise),
    .present     (port_present),
    .ready       (port_ready),
    .enable      (port_enable),
    .tx_done     (tx_done),
    .tx_ok       (tx_ok),
    .launch_req  (launch_req),
    .launch_port (launch_port),
    .busy        (busy),
    .done_ok     (done_ok),
    .done_err    (done_err)
  );

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPORT; p++) reg_rdata[init_pos(p)] = init_q[p];
    reg_rdata[OK_BIT]  = ok_q;
    reg_rdata[ERR_BIT] = err_q;
  end
endmodule

// File: rtl/stf_launch_checker.sv
module stf_launch_checker
  import stf_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'hE0
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic [NPORT-1:0]  port_present,
  input logic [NPORT-1:0]  port_ready,
  input logic              launch_req,
  input logic [PW-1:0]     launch_port,
  input logic              busy
);
  localparam logic [DW-1:0] LIVE = live_mask();

  logic             hit;
  logic [NPORT-1:0] ok_port_d;

  assign hit = reg_wr && (reg_addr == REG_OFFSET);

  always_ff @(posedge clk) begin
    if (rst) ok_port_d <= '0;
    else     ok_port_d <= port_present & port_ready;
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    launch_req |=> !launch_req);

  p_eligible_port_r3: assert property (@(posedge clk) disable iff (rst)
    launch_req |-> ok_port_d[launch_port]);

  p_busy_follows_launch_r8: assert property (@(posedge clk) disable iff (rst)
    launch_req |-> busy);

  p_no_launch_in_flight_r8: assert property (@(posedge clk) disable iff (rst)
    launch_req |-> !$past(busy));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~LIVE) == '0);

  p_ok_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && reg_rdata[OK_BIT] && !(hit && reg_wdata[OK_BIT])) |-> reg_rdata[OK_BIT]);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && reg_rdata[ERR_BIT] && !(hit && reg_wdata[ERR_BIT])) |-> reg_rdata[ERR_BIT]);
endmodule

bind stf_launch_ctrl stf_launch_checker #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .port_present (port_present),
  .port_ready   (port_ready),
  .launch_req   (launch_req),
  .launch_port  (launch_port),
  .busy         (busy)
);

// File: tb/sim_stf_launch_ctrl.sv
module sim_stf_launch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'hE0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  port_present = 4'hF;
  logic [3:0]  port_ready = 4'hF;
  logic [3:0]  port_enable = 4'hF;
  logic        tx_done = 1'b0;
  logic        tx_ok = 1'b0;
  logic        launch_req;
  logic [1:0]  launch_port;
  logic        busy;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  localparam logic [7:0] OFF = 8'hE0;
  localparam int OKB = 10;
  localparam int ERB = 9;

  always #10 clk = ~clk;

  stf_launch_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_present(port_present), .port_ready(port_ready),
    .port_enable(port_enable), .tx_done(tx_done), .tx_ok(tx_ok),
    .launch_req(launch_req), .launch_port(launch_port), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int bpos(input int p);
    case (p)
      0: return 7;
      1: return 8;
      2: return 11;
      default: return 13;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = OFF; reg_wdata = '0;
  endtask

  task automatic complete(input logic ok);
    tx_done = 1'b1; tx_ok = ok;
    tick();
    tx_done = 1'b0; tx_ok = 1'b0;
  endtask

  // write one initiate bit and look for the pulse two edges later
  task automatic try_launch(input int p, input logic exp, input string tag);
    wr(OFF, 32'(1) << bpos(p));
    tick();
    chk({tag, " launch_req"}, 32'(launch_req), 32'(exp));
    if (exp) chk("R11 launch_port", 32'(launch_port), 32'(p));
    tick();
    chk({tag, " pulse ended"}, 32'(launch_req), 32'd0);
  endtask

  initial begin
    repeat (5) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset rdata", reg_rdata, 32'd0);
    chk("R1 reset launch", 32'(launch_req), 32'd0);
    chk("R8 reset busy", 32'(busy), 32'd0);

    // R9: all ones, no device so no launch
    port_present = 4'h0;
    wr(OFF, 32'hFFFF_FFFF);
    chk("R9 reserved bits", reg_rdata, 32'h0000_2980);
    tick();
    chk("R3 no device no launch", 32'(launch_req), 32'd0);
    wr(OFF, 32'd0);
    port_present = 4'hF;

    // R1: other address ignored
    wr(8'hE4, 32'h0000_2980);
    chk("R1 other address", reg_rdata, 32'd0);
    tick();
    chk("R1 no launch from other address", 32'(launch_req), 32'd0);

    // R3 sweep: every port x presence x readiness, each launch fails (R4)
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic e;
        port_present = 4'hF; port_ready = 4'hF;
        port_present[p] = c[1];
        port_ready[p]   = c[0];
        e = (c == 3);
        try_launch(p, e, "R3 sweep");
        if (e) begin
          chk("R8 busy after launch", 32'(busy), 32'd1);
          complete(1'b0);
          chk("R4 failure flag", 32'(reg_rdata[ERB]), 32'd1);
          chk("R4 no success flag", 32'(reg_rdata[OKB]), 32'd0);
          chk("R8 busy cleared", 32'(busy), 32'd0);
          wr(OFF, 32'(1) << ERB);
        end else begin
          chk("R3 dropped not busy", 32'(busy), 32'd0);
          wr(OFF, 32'd0);
        end
        chk("R5 cleared", reg_rdata, 32'd0);
        tick();
        chk("R3 dropped edge not kept", 32'(launch_req), 32'd0);
      end
    end
    port_present = 4'hF; port_ready = 4'hF;

    // R6: repeated retries on port 2 after failures
    for (int k = 0; k < 3; k++) begin
      try_launch(2, 1'b1, "R6 retry");
      complete(1'b0);
      wr(OFF, 32'(1) << ERB);
    end

    // R2: bit held high gives one pulse
    begin
      int pulses = 0;
      wr(OFF, 32'(1) << bpos(3));
      for (int k = 0; k < 6; k++) begin
        tick();
        if (launch_req) pulses++;
      end
      chk("R2 one pulse while held", 32'(pulses), 32'd1);
      complete(1'b0);
      wr(OFF, 32'(1) << ERB);
    end

    // R8: edge while busy dropped; R4 success
    wr(OFF, 32'(1) << bpos(0));
    tick();
    chk("R8 first launch", 32'(launch_req), 32'd1);
    tick();
    wr(OFF, (32'(1) << bpos(0)) | (32'(1) << bpos(1)));
    tick();
    chk("R8 edge while busy dropped", 32'(launch_req), 32'd0);
    chk("R8 still busy", 32'(busy), 32'd1);
    complete(1'b1);
    chk("R4 success flag", 32'(reg_rdata[OKB]), 32'd1);
    chk("R4 no failure flag", 32'(reg_rdata[ERB]), 32'd0);
    repeat (3) begin
      tick();
      chk("R2 no pulse after busy clears", 32'(launch_req), 32'd0);
    end
    complete(1'b0);
    chk("R8 idle completion ignored", 32'(reg_rdata[ERB]), 32'd0);
    chk("R8 idle completion busy", 32'(busy), 32'd0);

    // R5: write 0 keeps the flag, write 1 clears it
    wr(OFF, 32'd0);
    chk("R5 write 0 keeps success", 32'(reg_rdata[OKB]), 32'd1);
    wr(OFF, 32'(1) << OKB);
    chk("R5 write 1 clears success", reg_rdata, 32'd0);

    // R7: port 0 locked, port 1 free
    try_launch(0, 1'b0, "R7 locked port");
    wr(OFF, 32'd0);
    try_launch(1, 1'b1, "R7 other port free");
    complete(1'b0);
    wr(OFF, 32'(1) << ERB);
    port_enable[0] = 1'b0;
    tick();
    port_enable[0] = 1'b1;
    tick();
    tick();
    try_launch(0, 1'b1, "R7 released after enable cycle");
    complete(1'b0);

    // R5: flag set still allows a launch
    wr(OFF, 32'd0);
    chk("R5 failure kept", 32'(reg_rdata[ERB]), 32'd1);
    try_launch(3, 1'b1, "R5 launch with flag set");
    complete(1'b0);
    wr(OFF, 32'(1) << ERB);
    chk("R5 failure cleared", reg_rdata, 32'd0);

    // R10: two ports at once, lowest wins
    wr(OFF, (32'(1) << bpos(1)) | (32'(1) << bpos(2)));
    tick();
    chk("R10 launch", 32'(launch_req), 32'd1);
    chk("R10 lowest port", 32'(launch_port), 32'd1);
    complete(1'b0);
    repeat (3) begin
      tick();
      chk("R10 loser dropped", 32'(launch_req), 32'd0);
    end
    wr(OFF, 32'(1) << ERB);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule